// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block is the architectural register store of an 8-bit processor core. It holds an accumulator with its flag byte, three general register pairs, two index registers, a stack pointer, a program counter, an interrupt vector base byte and a memory refresh counter. The accumulator/flags pair and the three general pairs each have a second, shadow copy.

Software-visible state is reached through one write port and one read port. Each port takes a width flag and a 4-bit select. With the flag high, a 16-bit pair is addressed. With the flag low, a single byte is addressed. The decoder drives two exchange strobes that switch banks in a single cycle. One strobe acts on the accumulator/flags pair alone. The other acts on the three general pairs together. A third strobe, pulsed once per opcode fetch, advances the refresh counter.

Reads are combinational from the stored state. Writes, exchanges and increments take effect at the rising clock edge.

Top module: `cpu_regfile`

## Requirements
- R1: A 16-bit write with `wr_wide`=1 stores `wr_data` into the pair selected by `wr_sel`: 0 AF, 1 BC, 2 DE, 3 HL, 4 SP, 5 PC, 6 IX, 7 IY. A 16-bit read with `rd_wide`=1 returns that pair. The first-named register is the high byte.
- R2: An 8-bit access with the width flag low uses byte codes 0 A, 1 F, 2 B, 3 C, 4 D, 5 E, 6 H, 7 L. A write changes only the addressed half of its pair, using `wr_data[7:0]`. A read returns the byte zero-extended in `rd_data`.
- R3: A pulse on `xchg_af` swaps the visible AF with its shadow copy. The general pairs are left untouched.
- R4: A pulse on `xchg_gen` swaps BC, DE and HL with their shadow copies together. AF is left untouched.
- R5: Byte codes 10 IXH, 11 IXL, 12 IYH and 13 IYL reach the halves of the index registers. Byte code 8 is the 8-bit interrupt vector base I.
- R6: Byte code 9 is the refresh counter R. Each `r_inc` pulse adds one to bits 6:0, wrapping from 127 to 0. Bit 7 keeps its last written value.
- R7: A write to R in the same cycle as `r_inc` loads the written value. The increment is dropped.
- R8: A write in the same cycle as an exchange that affects the addressed pair lands in the bank that was visible before the swap.
- R9: A low `rst_n` at a clock edge clears PC, I and R and selects the primary bank for both exchange groups. The other registers keep their contents.
- R10: A read in the same cycle as a write to the same register returns the old value. The new value is returned from the next cycle on.
- R11: Byte codes 14 and 15, and pair codes 8 to 15, read as zero. Writes to these codes change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_wide | input | 1 | 1: pair write, 0: byte write |
| wr_sel | input | 4 | Write register code |
| wr_data | input | 16 | Write data, low byte used for byte writes |
| xchg_af | input | 1 | Swap AF with its shadow |
| xchg_gen | input | 1 | Swap BC, DE, HL with their shadows |
| r_inc | input | 1 | Advance refresh counter |
| rd_wide | input | 1 | 1: pair read, 0: byte read |
| rd_sel | input | 4 | Read register code |
| rd_data | output | 16 | Read data, byte reads zero-extended |

## Verification
Two pairs of functions can fall in the same cycle. The first is an exchange strobe together with a write to a pair in the swapped group. The second is a refresh increment together with a direct write to R. The bench raises both strobes on one clock edge. For the exchange case, it then reads the visible copy and swaps back to read the other one, which shows which bank took the data. For the refresh case, it reads R once to see whether the load or the increment prevailed.

// File: rtl/rf_pkg.sv
// Package: shared register codes and widths for the dual-bank register file.
// Assumes byte codes fit in 4 bits; 5'd31 marks "no byte access".
package rf_pkg;

    localparam int NUM_PAIRS  = 8;
    localparam int NUM_BANKED = 4;
    localparam int PC_IDX     = 5;

    typedef enum logic [3:0] {
        BS_A   = 4'd0,  BS_F   = 4'd1,
        BS_B   = 4'd2,  BS_C   = 4'd3,
        BS_D   = 4'd4,  BS_E   = 4'd5,
        BS_H   = 4'd6,  BS_L   = 4'd7,
        BS_I   = 4'd8,  BS_R   = 4'd9,
        BS_IXH = 4'd10, BS_IXL = 4'd11,
        BS_IYH = 4'd12, BS_IYL = 4'd13
    } byte_sel_e;

    // Byte code of the high half of pair p, or 31 when the pair has none.
    function automatic logic [4:0] hi_code(input int p);
        case (p)
            0:       return 5'd0;
            1:       return 5'd2;
            2:       return 5'd4;
            3:       return 5'd6;
            6:       return 5'd10;
            7:       return 5'd12;
            default: return 5'd31;
        endcase
    endfunction

    // Byte code of the low half of pair p, or 31 when the pair has none.
    function automatic logic [4:0] lo_code(input int p);
        logic [4:0] h;
        h = hi_code(p);
        return (h == 5'd31) ? 5'd31 : h + 5'd1;
    endfunction

endpackage

// File: rtl/rf_banked_pair.sv
// Module: one register pair with a primary and a shadow copy.
// The bank input picks which copy is read and written; swapping the bank
// therefore costs no data movement. Assumes bank is a registered signal.
module rf_banked_pair #(
    parameter int BYTE_W = 8,
    localparam int PAIR_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              bank,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [PAIR_W-1:0] wr_data,
    output logic [PAIR_W-1:0] rd_q
);

    logic [PAIR_W-1:0] copy_q [2];

    // Update the halves of the currently selected copy.
    always_ff @(posedge clk) begin
        if (wr_hi) copy_q[bank][PAIR_W-1:BYTE_W] <= wr_data[PAIR_W-1:BYTE_W];
        if (wr_lo) copy_q[bank][BYTE_W-1:0]      <= wr_data[BYTE_W-1:0];
    end

    // Present the selected copy.
    assign rd_q = copy_q[bank];

endmodule

// File: rtl/rf_plain_pair.sv
// Module: one unbanked 16-bit register with independent half-writes.
// RST_EN selects whether synchronous reset clears it (program counter only).
module rf_plain_pair #(
    parameter int BYTE_W = 8,
    parameter bit RST_EN = 1'b0,
    localparam int PAIR_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [PAIR_W-1:0] wr_data,
    output logic [PAIR_W-1:0] rd_q
);

    // Clear on reset when enabled, otherwise load the written halves.
    always_ff @(posedge clk) begin
        if (RST_EN && !rst_n) begin
            rd_q <= '0;
        end else begin
            if (wr_hi) rd_q[PAIR_W-1:BYTE_W] <= wr_data[PAIR_W-1:BYTE_W];
            if (wr_lo) rd_q[BYTE_W-1:0]      <= wr_data[BYTE_W-1:0];
        end
    end

endmodule

// File: rtl/rf_refresh.sv
// Module: memory refresh counter. Only the bits below the top bit count;
// the top bit holds what was last written. A write takes priority over
// an increment in the same cycle. Assumes W >= 2.
module rf_refresh #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         inc,
    output logic [W-1:0] q
);

    // Reset, load, or step the low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (wr)  q <= wr_data;
        else if (inc) q <= {q[W-1], q[W-2:0] + 1'b1};
    end

    p_refresh_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr) |=> (q[W-2:0] == $past(q[W-2:0]) + 1'b1));

    p_refresh_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr) |=> (q[W-1] == $past(q[W-1])));

    p_refresh_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (q == $past(wr_data)));

endmodule

// File: rtl/cpu_regfile.sv
// Module: dual-bank CPU register file (top).
// Holds AF/BC/DE/HL with shadows, SP, PC, IX, IY, I and R. One write port
// and one combinational read port, each with a pair/byte width flag.
// Two bank-select flip-flops implement the exchanges. Assumes the decoder
// drives at most one write per cycle.
module cpu_regfile #(
    parameter int BYTE_W = 8,
    localparam int PAIR_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_wide,
    input  logic [3:0]        wr_sel,
    input  logic [PAIR_W-1:0] wr_data,
    input  logic              xchg_af,
    input  logic              xchg_gen,
    input  logic              r_inc,
    input  logic              rd_wide,
    input  logic [3:0]        rd_sel,
    output logic [PAIR_W-1:0] rd_data
);
    import rf_pkg::*;

    logic              af_bank;
    logic              gen_bank;
    logic [PAIR_W-1:0] pair_q [NUM_PAIRS];
    logic [PAIR_W-1:0] pair_wdata;
    logic [BYTE_W-1:0] i_q;
    logic [BYTE_W-1:0] r_q;
    logic              wr_byte;
    logic [BYTE_W-1:0] rd_byte;

    // Toggle each bank select on its exchange strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            af_bank  <= 1'b0;
            gen_bank <= 1'b0;
        end else begin
            if (xchg_af)  af_bank  <= ~af_bank;
            if (xchg_gen) gen_bank <= ~gen_bank;
        end
    end

    assign wr_byte    = wr_en && !wr_wide;
    assign pair_wdata = wr_wide ? wr_data : {wr_data[BYTE_W-1:0], wr_data[BYTE_W-1:0]};

    // One storage element per pair; the first four are banked.
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam logic [4:0] HI = hi_code(p);
        localparam logic [4:0] LO = lo_code(p);
        logic wide_hit;
        logic wr_hi;
        logic wr_lo;

        assign wide_hit = wr_en && wr_wide && (wr_sel == 4'(p));
        assign wr_hi    = wide_hit || (wr_byte && ({1'b0, wr_sel} == HI));
        assign wr_lo    = wide_hit || (wr_byte && ({1'b0, wr_sel} == LO));

        if (p < NUM_BANKED) begin : g_banked
            rf_banked_pair #(.BYTE_W(BYTE_W)) u_pair (
                .clk     (clk),
                .bank    ((p == 0) ? af_bank : gen_bank),
                .wr_hi   (wr_hi),
                .wr_lo   (wr_lo),
                .wr_data (pair_wdata),
                .rd_q    (pair_q[p])
            );
        end else begin : g_plain
            rf_plain_pair #(.BYTE_W(BYTE_W), .RST_EN(p == PC_IDX)) u_pair (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_hi   (wr_hi),
                .wr_lo   (wr_lo),
                .wr_data (pair_wdata),
                .rd_q    (pair_q[p])
            );
        end
    end

    // Interrupt vector base: cleared on reset, loaded by byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   i_q <= '0;
        else if (wr_byte && wr_sel == 4'(BS_I))       i_q <= wr_data[BYTE_W-1:0];
    end

    rf_refresh #(.W(BYTE_W)) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_byte && wr_sel == 4'(BS_R)),
        .wr_data (wr_data[BYTE_W-1:0]),
        .inc     (r_inc),
        .q       (r_q)
    );

    // Select the byte addressed by a narrow read.
    always_comb begin
        case (rd_sel)
            4'(BS_A):   rd_byte = pair_q[0][PAIR_W-1:BYTE_W];
            4'(BS_F):   rd_byte = pair_q[0][BYTE_W-1:0];
            4'(BS_B):   rd_byte = pair_q[1][PAIR_W-1:BYTE_W];
            4'(BS_C):   rd_byte = pair_q[1][BYTE_W-1:0];
            4'(BS_D):   rd_byte = pair_q[2][PAIR_W-1:BYTE_W];
            4'(BS_E):   rd_byte = pair_q[2][BYTE_W-1:0];
            4'(BS_H):   rd_byte = pair_q[3][PAIR_W-1:BYTE_W];
            4'(BS_L):   rd_byte = pair_q[3][BYTE_W-1:0];
            4'(BS_I):   rd_byte = i_q;
            4'(BS_R):   rd_byte = r_q;
            4'(BS_IXH): rd_byte = pair_q[6][PAIR_W-1:BYTE_W];
            4'(BS_IXL): rd_byte = pair_q[6][BYTE_W-1:0];
            4'(BS_IYH): rd_byte = pair_q[7][PAIR_W-1:BYTE_W];
            4'(BS_IYL): rd_byte = pair_q[7][BYTE_W-1:0];
            default:    rd_byte = '0;
        endcase
    end

    // Drive the read port for either width.
    always_comb begin
        if (rd_wide) rd_data = rd_sel[3] ? '0 : pair_q[rd_sel[2:0]];
        else         rd_data = {{BYTE_W{1'b0}}, rd_byte};
    end

    p_reset_state_r9: assert property (@(posedge clk)
        !rst_n |=> (pair_q[PC_IDX] == '0 && i_q == '0 && r_q == '0 && !af_bank && !gen_bank));

    p_af_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_af |=> (af_bank != $past(af_bank)));

    p_gen_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xchg_gen |=> (gen_bank != $past(gen_bank)));

    p_af_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_gen && !xchg_af) |=> $stable(af_bank));

    p_gen_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_af && !xchg_gen) |=> $stable(gen_bank));

endmodule

// File: tb/cpu_regfile_tb_top.sv
// Bench: vector table walked by one loop, then directed reset and
// read-during-write tests. 125 MHz clock.
module cpu_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_wide = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        xchg_af = 1'b0;
    logic        xchg_gen = 1'b0;
    logic        r_inc = 1'b0;
    logic        rd_wide = 1'b0;
    logic [3:0]  rd_sel = '0;
    logic [15:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    cpu_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide),
        .wr_sel(wr_sel), .wr_data(wr_data), .xchg_af(xchg_af),
        .xchg_gen(xchg_gen), .r_inc(r_inc), .rd_wide(rd_wide),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    // Fields: we wd ws[4] wdat[16] xa xg ri rw rs[4] exp[16] req[4]
    localparam int NV = 31;
    localparam logic [49:0] VEC [NV] = '{
        {1'b1,1'b1,4'd0, 16'h1234,1'b0,1'b0,1'b0,1'b1,4'd0, 16'h1234,4'd1},  // R1 AF
        {1'b1,1'b1,4'd1, 16'h5678,1'b0,1'b0,1'b0,1'b0,4'd2, 16'h0056,4'd2},  // R2 B
        {1'b1,1'b0,4'd3, 16'h009A,1'b0,1'b0,1'b0,1'b1,4'd1, 16'h569A,4'd2},  // R2 C
        {1'b1,1'b1,4'd2, 16'hBEEF,1'b0,1'b0,1'b0,1'b0,4'd5, 16'h00EF,4'd1},  // R1 E
        {1'b1,1'b1,4'd3, 16'hCAFE,1'b0,1'b0,1'b0,1'b1,4'd3, 16'hCAFE,4'd1},  // R1 HL
        {1'b0,1'b0,4'd0, 16'h0000,1'b1,1'b0,1'b0,1'b1,4'd1, 16'h569A,4'd3},  // R3 BC untouched
        {1'b1,1'b1,4'd0, 16'hA5A5,1'b0,1'b0,1'b0,1'b1,4'd0, 16'hA5A5,4'd3},  // R3 shadow AF
        {1'b0,1'b0,4'd0, 16'h0000,1'b1,1'b0,1'b0,1'b1,4'd0, 16'h1234,4'd3},  // R3 back
        {1'b0,1'b0,4'd0, 16'h0000,1'b0,1'b1,1'b0,1'b1,4'd0, 16'h1234,4'd4},  // R4 AF kept
        {1'b1,1'b1,4'd3, 16'h0F0F,1'b0,1'b0,1'b0,1'b1,4'd3, 16'h0F0F,4'd4},  // R4 shadow HL
        {1'b0,1'b0,4'd0, 16'h0000,1'b0,1'b1,1'b0,1'b1,4'd3, 16'hCAFE,4'd4},  // R4 back
        {1'b0,1'b0,4'd0, 16'h0000,1'b0,1'b1,1'b0,1'b1,4'd3, 16'h0F0F,4'd4},  // R4 shadow
        {1'b1,1'b1,4'd1, 16'h7777,1'b0,1'b1,1'b0,1'b1,4'd1, 16'h569A,4'd8},  // R8 write+swap
        {1'b0,1'b0,4'd0, 16'h0000,1'b0,1'b1,1'b0,1'b1,4'd1, 16'h7777,4'd8},  // R8 landed
        {1'b0,1'b0,4'd0, 16'h0000,1'b0,1'b1,1'b0,1'b1,4'd2, 16'hBEEF,4'd4},  // R4 primary
        {1'b1,1'b0,4'd0, 16'h003C,1'b1,1'b0,1'b0,1'b1,4'd0, 16'hA5A5,4'd8},  // R8 A+swap
        {1'b0,1'b0,4'd0, 16'h0000,1'b1,1'b0,1'b0,1'b1,4'd0, 16'h3C34,4'd8},  // R8 landed
        {1'b1,1'b1,4'd4, 16'hFFFE,1'b0,1'b0,1'b0,1'b1,4'd4, 16'hFFFE,4'd1},  // R1 SP
        {1'b1,1'b1,4'd6, 16'h1357,1'b0,1'b0,1'b0,1'b0,4'd10,16'h0013,4'd5},  // R5 IXH
        {1'b1,1'b1,4'd7, 16'h2468,1'b0,1'b0,1'b0,1'b0,4'd13,16'h0068,4'd5},  // R5 IYL
        {1'b1,1'b0,4'd13,16'h0099,1'b0,1'b0,1'b0,1'b1,4'd7, 16'h2499,4'd5},  // R5 IYL write
        {1'b1,1'b0,4'd8, 16'h0042,1'b0,1'b0,1'b0,1'b0,4'd8, 16'h0042,4'd5},  // R5 I
        {1'b1,1'b1,4'd5, 16'h0100,1'b0,1'b0,1'b0,1'b1,4'd5, 16'h0100,4'd1},  // R1 PC
        {1'b1,1'b0,4'd9, 16'h007E,1'b0,1'b0,1'b0,1'b0,4'd9, 16'h007E,4'd6},  // R6 load
        {1'b0,1'b0,4'd0, 16'h0000,1'b0,1'b0,1'b1,1'b0,4'd9, 16'h007F,4'd6},  // R6 step
        {1'b0,1'b0,4'd0, 16'h0000,1'b0,1'b0,1'b1,1'b0,4'd9, 16'h0000,4'd6},  // R6 wrap
        {1'b1,1'b0,4'd9, 16'h00FF,1'b0,1'b0,1'b0,1'b0,4'd9, 16'h00FF,4'd6},  // R6 load top
        {1'b0,1'b0,4'd0, 16'h0000,1'b0,1'b0,1'b1,1'b0,4'd9, 16'h0080,4'd6},  // R6 top held
        {1'b1,1'b0,4'd9, 16'h0005,1'b0,1'b0,1'b1,1'b0,4'd9, 16'h0005,4'd7},  // R7 write wins
        {1'b1,1'b0,4'd14,16'h0055,1'b0,1'b0,1'b0,1'b0,4'd14,16'h0000,4'd11}, // R11 code 14
        {1'b1,1'b1,4'd9, 16'hDEAD,1'b0,1'b0,1'b0,1'b1,4'd3, 16'hCAFE,4'd11}  // R11 pair 9
    };

    task automatic check(input int req, input logic [15:0] exp);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL R%0d: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    task automatic read_chk(input logic w, input logic [3:0] s, input int req,
                            input logic [15:0] exp);
        @(negedge clk);
        rd_wide = w;
        rd_sel  = s;
        #1 check(req, exp);
    endtask

    task automatic pulse_clear();
        @(posedge clk);
        #1;
        wr_en = 1'b0; xchg_af = 1'b0; xchg_gen = 1'b0; r_inc = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9 reset state of PC, I, R
        read_chk(1'b1, 4'd5, 9, 16'h0000);
        read_chk(1'b0, 4'd8, 9, 16'h0000);
        read_chk(1'b0, 4'd9, 9, 16'h0000);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            {wr_en, wr_wide, wr_sel, wr_data, xchg_af, xchg_gen, r_inc,
             rd_wide, rd_sel} = VEC[k][49:20];
            pulse_clear();
            check(int'(VEC[k][3:0]), VEC[k][19:4]);
        end
        read_chk(1'b1, 4'd0, 11, 16'h3C34);  // R11 AF unchanged

        // R10 read during write returns old value
        @(negedge clk);
        wr_en = 1'b1; wr_wide = 1'b1; wr_sel = 4'd0; wr_data = 16'h0BAD;
        rd_wide = 1'b1; rd_sel = 4'd0;
        #1 check(10, 16'h3C34);
        pulse_clear();
        check(10, 16'h0BAD);

        // R9 reset returns both banks to primary, keeps pairs
        @(negedge clk);
        xchg_af = 1'b1; xchg_gen = 1'b1;
        pulse_clear();
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        read_chk(1'b1, 4'd0, 9, 16'h0BAD);
        read_chk(1'b1, 4'd3, 9, 16'hCAFE);
        read_chk(1'b1, 4'd5, 9, 16'h0000);
        read_chk(1'b0, 4'd8, 9, 16'h0000);
        read_chk(1'b0, 4'd9, 9, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule